// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes two-channel serial PCM audio as three wires (a bit clock, a word clock and a data line) and turns each frame into a pair of parallel 24-bit samples. It handles four framings: I2S, left-justified, right-justified and a pulse-framed DSP mode. In right-justified mode the word length sets where capture starts; in the other modes any word of up to 24 bits is accepted. The framing and the word length come from two static control inputs.

All three serial lines are sampled in the system clock domain, and the bit clock edges are found by comparing its registered level across cycles. Each received word is two's complement, MSB first, and is placed at the top of the 24-bit output with zeros below. When a right word completes after a left word of the same frame, both outputs update together and a one-cycle valid strobe is raised. A change of either control input drops the frame in progress.

Top module: `serial_pcm_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `left_o` and `right_o` are zero and `valid_o` is low, whatever the state before the reset.
- R2: With `fmt_i` = 0 (left-justified), word clock high marks the left word and low the right word, data is taken on rising bit clock edges, and the first bit after a word clock change is the MSB.
- R3: With `fmt_i` = 1 (I2S), word clock low marks the left word and high the right word, data is taken on rising edges, and the bit taken at the first rising edge after a word clock change is ignored; the MSB follows one bit clock later.
- R4: With `fmt_i` = 3 (DSP), data is taken on falling bit clock edges; a word clock high pulse precedes each word, whose MSB is the first bit taken with the word clock low again; the first word after reset or a control change is left and words then alternate left, right.
- R5: With `fmt_i` = 2 (right-justified, 32 bit clocks per word clock half), capture starts at bit position 32 − W counted from 0 at the word clock change, where W is 16, 18, 20 or 24 for `wlen_i` = 0, 1, 2, 3; earlier bits are ignored. Word clock polarity is as in R2.
- R6: A word shorter than 24 bits appears in the upper bits of the output with zeros in the bits below.
- R7: Outside right-justified mode, `wlen_i` has no effect, a word may have any length up to 24 bits, and bits after the 24th bit of a word are ignored.
- R8: In left-justified mode a packed frame of 16 bit clocks per word clock half (32 per frame) is received correctly.
- R9: `valid_o` pulses for exactly one cycle once per frame, when a right word ends after a left word of the same frame (left always first); `left_o` and `right_o` change only in that cycle. A word ends at the next word clock change (DSP: the next word clock pulse).
- R10: A change of `fmt_i` or `wlen_i` discards the partial frame and raises no `valid_o` until a complete left and right word have been received under the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 DSP |
| wlen_i | input | 2 | Right-justified word length: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Serial word clock (channel select or frame pulse) |
| sdat_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Last complete left sample, top-aligned two's complement |
| right_o | output | 24 | Last complete right sample, top-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe when both samples update |

## Verification
The checks assume the bit clock is much slower than `clk`, with each level held for at least two system cycles, and that word clock and data stay steady across the sampling edge of the chosen framing. The bench holds each bit clock phase for four system cycles and changes word clock and data together with the opposite bit clock edge, so the sampling edge always finds settled values. Control inputs are changed only between bit clock edges at a system clock falling edge, and a fresh sequence always begins from reset with two idle bits at the right-word level.

// File: rtl/serial_pcm_rx_pkg.sv
package serial_pcm_rx_pkg;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_18 = 2'd1,
        WL_20 = 2'd2,
        WL_24 = 2'd3
    } wlen_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        fmt_e  fmt;
        wlen_e wlen;
    } cfg_t;

    // one system-clock view of the serial lines
    typedef struct packed {
        logic rise;
        logic fall;
        logic wcl;
        logic dat;
    } line_evt_t;

    function automatic int word_bits(wlen_e wl);
        case (wl)
            WL_16:   return 16;
            WL_18:   return 18;
            WL_20:   return 20;
            default: return 24;
        endcase
    endfunction

    // bit position (counted from the word boundary) that carries the MSB
    function automatic int first_bit(cfg_t c, int half);
        case (c.fmt)
            FMT_I2S: return 1;
            FMT_RJ:  return half - word_bits(c.wlen);
            default: return 0;
        endcase
    endfunction

    // number of bits kept from one word
    function automatic int bit_limit(cfg_t c, int full);
        if (c.fmt == FMT_RJ) return word_bits(c.wlen);
        return full;
    endfunction

endpackage

// File: rtl/serial_pcm_rx_edge.sv
module serial_pcm_rx_edge
    import serial_pcm_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk_i,
    input  logic      wclk_i,
    input  logic      sdat_i,
    output line_evt_t ev_o
);

    logic bclk_q, bclk_d, wclk_q, sdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            bclk_d <= 1'b0;
            wclk_q <= 1'b0;
            sdat_q <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            bclk_d <= bclk_q;
            wclk_q <= wclk_i;
            sdat_q <= sdat_i;
        end
    end

    assign ev_o.rise = bclk_q & ~bclk_d;
    assign ev_o.fall = ~bclk_q & bclk_d;
    assign ev_o.wcl  = wclk_q;
    assign ev_o.dat  = sdat_q;

endmodule

// File: rtl/serial_pcm_rx_frame.sv
module serial_pcm_rx_frame
    import serial_pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int HALF_BITS = 32,
    parameter int IDX_W     = 6,
    parameter int POS_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_i,
    input  line_evt_t        ev_i,
    output logic             flush_o,
    output logic             start_o,
    output logic             done_o,
    output chan_e            done_ch_o,
    output logic             cap_o,
    output logic [POS_W-1:0] pos_o,
    output logic             dat_o
);

    cfg_t             cfg_q;
    logic             primed, wprev, in_word;
    chan_e            cur_ch, dsp_ch;
    logic [IDX_W-1:0] idx;

    logic             is_dsp, smp, act;
    logic             start_c, done_c, in_n;
    chan_e            ch_n;
    logic [IDX_W-1:0] idx_n, off, lim, rel;

    assign flush_o = (cfg_i != cfg_q);
    assign is_dsp  = (cfg_q.fmt == FMT_DSP);
    assign smp     = !flush_o && (is_dsp ? ev_i.fall : ev_i.rise);
    assign act     = smp && primed;
    assign off     = IDX_W'(first_bit(cfg_q, HALF_BITS));
    assign lim     = IDX_W'(bit_limit(cfg_q, SAMPLE_W));

    always_comb begin
        start_c = 1'b0;
        done_c  = 1'b0;
        in_n    = in_word;
        ch_n    = cur_ch;
        if (is_dsp) begin
            if (ev_i.wcl && !wprev) begin
                done_c = in_word;
                in_n   = 1'b0;
            end else if (!ev_i.wcl && wprev) begin
                start_c = 1'b1;
                in_n    = 1'b1;
                ch_n    = dsp_ch;
            end
        end else if (ev_i.wcl != wprev) begin
            done_c  = in_word;
            start_c = 1'b1;
            in_n    = 1'b1;
            if (cfg_q.fmt == FMT_I2S) ch_n = ev_i.wcl ? CH_RIGHT : CH_LEFT;
            else                      ch_n = ev_i.wcl ? CH_LEFT : CH_RIGHT;
        end
        if (start_c)          idx_n = '0;
        else if (idx != '1)   idx_n = idx + IDX_W'(1);
        else                  idx_n = idx;
        rel = idx_n - off;
    end

    assign start_o   = act && start_c;
    assign done_o    = act && done_c;
    assign done_ch_o = cur_ch;
    assign cap_o     = act && in_n && (idx_n >= off) && (rel < lim);
    assign pos_o     = rel[POS_W-1:0];
    assign dat_o     = ev_i.dat;

    always_ff @(posedge clk) begin
        if (rst || flush_o) begin
            cfg_q   <= cfg_i;
            primed  <= 1'b0;
            wprev   <= 1'b0;
            in_word <= 1'b0;
            idx     <= '0;
            cur_ch  <= CH_LEFT;
            dsp_ch  <= CH_LEFT;
        end else if (smp) begin
            wprev <= ev_i.wcl;
            if (!primed) begin
                primed <= 1'b1;
            end else begin
                in_word <= in_n;
                idx     <= idx_n;
                cur_ch  <= ch_n;
                if (start_c && is_dsp) dsp_ch <= (dsp_ch == CH_LEFT) ? CH_RIGHT : CH_LEFT;
            end
        end
    end

endmodule

// File: rtl/serial_pcm_rx_shift.sv
module serial_pcm_rx_shift #(
    parameter int SAMPLE_W = 24,
    parameter int POS_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                cap_i,
    input  logic [POS_W-1:0]    pos_i,
    input  logic                dat_i,
    output logic [SAMPLE_W-1:0] word_o
);

    logic [SAMPLE_W-1:0] acc, nxt;

    for (genvar g = 0; g < SAMPLE_W; g++) begin : g_bit
        always_comb begin
            if (cap_i && pos_i == POS_W'(SAMPLE_W - 1 - g)) nxt[g] = dat_i;
            else if (start_i)                               nxt[g] = 1'b0;
            else                                            nxt[g] = acc[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  acc <= '0;
        else if (start_i || cap_i) acc <= nxt;
    end

    assign word_o = acc;

endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
    import serial_pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int HALF_BITS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                bclk_i,
    input  logic                wclk_i,
    input  logic                sdat_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam int POS_W = $clog2(SAMPLE_W);
    localparam int IDX_W = $clog2(HALF_BITS) + 1;

    cfg_t                cfg_w;
    line_evt_t           ev;
    logic                cfg_flush, word_start, word_done, bit_cap, bit_dat;
    chan_e               done_ch;
    logic [POS_W-1:0]    bit_pos;
    logic [SAMPLE_W-1:0] acc_word, left_hold;
    logic                left_ok;

    assign cfg_w.fmt  = fmt_e'(fmt_i);
    assign cfg_w.wlen = wlen_e'(wlen_i);

    serial_pcm_rx_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .bclk_i (bclk_i),
        .wclk_i (wclk_i),
        .sdat_i (sdat_i),
        .ev_o   (ev)
    );

    serial_pcm_rx_frame #(
        .SAMPLE_W  (SAMPLE_W),
        .HALF_BITS (HALF_BITS),
        .IDX_W     (IDX_W),
        .POS_W     (POS_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg_w),
        .ev_i      (ev),
        .flush_o   (cfg_flush),
        .start_o   (word_start),
        .done_o    (word_done),
        .done_ch_o (done_ch),
        .cap_o     (bit_cap),
        .pos_o     (bit_pos),
        .dat_o     (bit_dat)
    );

    serial_pcm_rx_shift #(
        .SAMPLE_W (SAMPLE_W),
        .POS_W    (POS_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start_i (word_start),
        .cap_i   (bit_cap),
        .pos_i   (bit_pos),
        .dat_i   (bit_dat),
        .word_o  (acc_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
            left_hold <= '0;
            left_ok   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cfg_flush) begin
                left_ok <= 1'b0;
            end else if (word_done) begin
                if (done_ch == CH_LEFT) begin
                    left_hold <= acc_word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_o  <= left_hold;
                    right_o <= acc_word;
                    valid_o <= 1'b1;
                    left_ok <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/serial_pcm_rx_chk.sv
module serial_pcm_rx_chk #(
    parameter int SAMPLE_W = 24,
    parameter int POS_W    = 5
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          fmt_i,
    input logic [1:0]          wlen_i,
    input logic                valid_o,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                done,
    input logic                done_ch,
    input logic                cap,
    input logic [POS_W-1:0]    pos
);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    left_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(left_o) |-> valid_o);

    // R9
    right_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(right_o) |-> valid_o);

    // R9
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(done && done_ch));

    // R10
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ({fmt_i, wlen_i} != $past({fmt_i, wlen_i})) |=> !valid_o);

    // R7
    cap_range_chk: assert property (@(posedge clk) disable iff (rst)
        cap |-> (int'(pos) < SAMPLE_W));

endmodule

bind serial_pcm_rx serial_pcm_rx_chk #(
    .SAMPLE_W (SAMPLE_W),
    .POS_W    (POS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fmt_i   (fmt_i),
    .wlen_i  (wlen_i),
    .valid_o (valid_o),
    .left_o  (left_o),
    .right_o (right_o),
    .done    (word_done),
    .done_ch (done_ch),
    .cap     (bit_cap),
    .pos     (bit_pos)
);

// File: tb/serial_pcm_rx_tb.sv
`timescale 1ns/1ps
module serial_pcm_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wlen = 2'd3;
    logic        bclk = 1'b0, wclk = 1'b0, sdat = 1'b0;
    logic [23:0] left, right;
    logic        valid;

    int          checks = 0, fails = 0;
    logic [23:0] exp_l[$], exp_r[$];
    string       exp_tag[$];
    string       quiet_tag = "R9";
    logic        prev_valid = 1'b0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_pcm_rx u_dut (
        .clk     (clk),
        .rst     (rst),
        .fmt_i   (fmt),
        .wlen_i  (wlen),
        .bclk_i  (bclk),
        .wclk_i  (wclk),
        .sdat_i  (sdat),
        .left_o  (left),
        .right_o (right),
        .valid_o (valid)
    );

    task automatic chk(bit ok, string tag, string what, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference queue compared on every clock
    always @(negedge clk) begin
        if (rst) begin
            prev_valid = 1'b0;
        end else begin
            if (valid) begin
                if (exp_l.size() == 0) begin
                    chk(1'b0, quiet_tag, "unexpected valid, left", left, 24'h0);
                end else begin
                    logic [23:0] el, er;
                    string t;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    t  = exp_tag.pop_front();
                    chk(left == el, t, "left sample", left, el);
                    chk(right == er, t, "right sample", right, er);
                end
                if (prev_valid) chk(1'b0, "R9", "valid wider than one cycle", 24'h1, 24'h0);
            end
            prev_valid = valid;
        end
    end

    function automatic logic [23:0] top_align(logic [31:0] w, int n);
        if (n >= 24) return 24'(w >> (n - 24));
        return 24'(w << (24 - n));
    endfunction

    function automatic logic get_bit(logic [31:0] w, int n, int k);
        if (k < n) return w[n - 1 - k];
        return 1'b0;
    endfunction

    task automatic drive_bit(logic w, logic d);
        if (fmt == 2'd3) begin
            bclk = 1'b1; wclk = w; sdat = d;
            repeat (4) @(negedge clk);
            bclk = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            bclk = 1'b0; wclk = w; sdat = d;
            repeat (4) @(negedge clk);
            bclk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic send_half(bit is_left, int n, int half, logic [31:0] w);
        case (fmt)
            2'd0: for (int i = 0; i < half; i++) drive_bit(is_left, get_bit(w, n, i));
            2'd1: for (int i = 0; i < half; i++)
                      drive_bit(!is_left, (i == 0) ? 1'b1 : get_bit(w, n, i - 1));
            2'd2: for (int i = 0; i < half; i++)
                      drive_bit(is_left, (i < half - n) ? 1'b1 : get_bit(w, n, i - (half - n)));
            default: begin
                drive_bit(1'b1, 1'b1);
                for (int i = 0; i < half - 1; i++) drive_bit(1'b0, get_bit(w, n, i));
            end
        endcase
    endtask

    task automatic send_frame(int n, int half, logic [31:0] l, logic [31:0] r,
                              bit expect_v, string tag);
        logic [31:0] m;
        m = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        send_half(1'b1, n, half, l & m);
        send_half(1'b0, n, half, r & m);
        if (expect_v) begin
            exp_l.push_back(top_align(l & m, n));
            exp_r.push_back(top_align(r & m, n));
            exp_tag.push_back(tag);
        end
    endtask

    task automatic start_seq(logic [1:0] f, logic [1:0] wl);
        rst = 1'b1;
        bclk = 1'b0; wclk = 1'b0; sdat = 1'b0;
        fmt = f; wlen = wl;
        quiet_tag = "R9";
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs cleared after reset
        chk(left == 24'h0, "R1", "left after reset", left, 24'h0);
        chk(right == 24'h0, "R1", "right after reset", right, 24'h0);
        chk({23'h0, valid} == 24'h0, "R1", "valid after reset", {23'h0, valid}, 24'h0);
        drive_bit((f == 2'd1), 1'b0);
        drive_bit((f == 2'd1), 1'b0);
    endtask

    task automatic end_seq();
        drive_bit((fmt != 2'd1), 1'b0);
        drive_bit((fmt != 2'd1), 1'b0);
        repeat (10) @(negedge clk);
        chk(exp_l.size() == 0, "R9", "frames without valid", 24'(exp_l.size()), 24'h0);
        exp_l.delete(); exp_r.delete(); exp_tag.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // R2: left-justified, 24-bit words
        start_seq(2'd0, 2'd3);
        send_frame(24, 32, 32'h80_0001, 32'h7F_FFFF, 1'b1, "R2");
        send_frame(24, 32, 32'h12_3456, 32'hFE_DCBA, 1'b1, "R2");
        send_frame(24, 32, 32'h00_0000, 32'hFF_FFFF, 1'b1, "R2");
        end_seq();

        // R3: I2S, then R6 with a 20-bit word
        start_seq(2'd1, 2'd0);
        send_frame(24, 32, 32'hA5_5A5A, 32'h5A_A5A5, 1'b1, "R3");
        send_frame(24, 32, 32'h80_0000, 32'h00_0001, 1'b1, "R3");
        send_frame(20, 32, 32'h8_0001, 32'h7_FFFE, 1'b1, "R6");
        end_seq();

        // R4: DSP pulse framing, then R6 with a 16-bit word
        start_seq(2'd3, 2'd1);
        send_frame(24, 32, 32'hC0_FFEE, 32'h13_5791, 1'b1, "R4");
        send_frame(24, 32, 32'h01_0203, 32'hFF_0000, 1'b1, "R4");
        send_frame(16, 32, 32'h7FFF, 32'h8001, 1'b1, "R6");
        end_seq();

        // R5: right-justified, every word length
        for (int k = 0; k < 4; k++) begin
            int n;
            n = (k == 0) ? 16 : (k == 1) ? 18 : (k == 2) ? 20 : 24;
            start_seq(2'd2, 2'(k));
            send_frame(n, 32, 32'h00AB_CDEF, 32'h0012_3457, 1'b1, "R5");
            send_frame(n, 32, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R5");
            end_seq();
        end

        // R7: left-justified 28-bit words, word length setting irrelevant
        start_seq(2'd0, 2'd0);
        send_frame(28, 32, 32'h0ABC_DEF5, 32'h0876_5432, 1'b1, "R7");
        send_frame(28, 32, 32'h0FFF_FFF7, 32'h0000_0018, 1'b1, "R7");
        end_seq();

        // R8: packed 16 bit clocks per half
        start_seq(2'd0, 2'd3);
        send_frame(16, 16, 32'h8421, 32'h1248, 1'b1, "R8");
        send_frame(16, 16, 32'h7FFE, 32'hC003, 1'b1, "R8");
        send_frame(16, 16, 32'h0001, 32'hFFFF, 1'b1, "R8");
        end_seq();

        // R10: word length change mid-frame drops that frame
        start_seq(2'd0, 2'd3);
        send_frame(24, 32, 32'h11_2233, 32'h44_5566, 1'b1, "R10");
        send_half(1'b1, 24, 32, 32'h77_8899);
        wlen = 2'd0;
        quiet_tag = "R10";
        send_half(1'b0, 24, 32, 32'hAA_BBCC);
        drive_bit(1'b0, 1'b0);
        drive_bit(1'b0, 1'b0);
        send_frame(24, 32, 32'h65_4321, 32'h9A_BCDE, 1'b1, "R10");
        end_seq();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule